// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes a new oscillator configuration and applies it to a PLL in a fixed order of register-field writes. The configuration is a target oscillator rate and a parent (input) rate, both in kHz, a reference divider, an integer and a fractional feedback divider, a flag that says whether the fractional divider exists, and the reset polarity. On a start pulse the block captures the configuration and classifies the oscillator rate and the derived reference rate into bands. It picks the loop-filter gains from those bands. It then drives the PLL control fields one write per cycle and polls the PLL lock flag a bounded number of times.

An out-of-range rate ends the transaction before any field is touched. A lock flag that is never seen also ends it, with an error. Each field is a registered output that stands for the matching PLL control register field. A step code output names the field written in each cycle, so that neighbouring logic can mirror the writes.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, all fields, the step code, `busy_o`, `done_o`, `err_code_o` and `locked_o` are 0, except `vco_upper_o`, which is all ones.
- R2: The oscillator rate selects the gains. A rate in [700000, 2200000) kHz gives ki 4 and the mid row. A rate in [2200000, 3100000) gives ki 3 and the high row. A rate in [3100000, 4000000) gives ki 3 and the top row. Any other rate ends the transaction with `err_code_o`=1 and one `done_o` pulse, and no step code appears.
- R3: The reference rate is the parent rate divided by the reference divider, and is twice the parent rate when the divider is 0. It must lie in one of eight half-open bands with edges 10000, 12500, 15000, 20000, 25000, 50000, 75000, 100000, 125000 kHz (band 0 lowest). Outside them, `err_code_o`=2 and nothing is written. When both rates are bad, code 1 wins.
- R4: kp is table[row][band]. The mid row is 5,6,6,7,7,8,9,10, the high row is 4,4,5,5,6,7,8,9 and the top row is 4,5,5,6,7,8,9,10, each listed from band 0 to band 7.
- R5: An accepted transaction emits step codes on consecutive cycles in this order: 1 power-up, 2 reset assert, 3 mode, 4 upper word clear, 5 lower word, 6 integer divider, 7 fractional divider, 8 reference divider, 9 gains, 10 reset release. Code 0 means no write.
- R6: The upper oscillator word is written 0. In the lower word, bit 30 is set for a rate in [700000, 1200000) and left unchanged otherwise. Bit 19 is set for a rate of 2200000 or above and cleared otherwise.
- R7: `pll_rst_o` is 2'b11 while reset is asserted and 2'b00 when it is released if `rst_active_low_i`=1. With `rst_active_low_i`=0 the two values are swapped.
- R8: With `has_frac_i`=0, step 7 is skipped and `ndiv_frac_o` keeps its previous value.
- R9: After reset release, the lock flag is sampled every POLL_GAP cycles, at most MAX_POLLS times (defaults 4 and 100). If it is seen high, `locked_o`=1 and `done_o` pulses with `err_code_o`=0. Otherwise `err_code_o`=3, `locked_o`=0 and `done_o` pulses.
- R10: The mode field is written 7, ka is written 0, and the divider fields take the captured configuration values.
- R11: A start pulse while `busy_o` is high is ignored, and the transaction in progress completes with its captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, captures configuration |
| vco_khz_i | input | 32 | Target oscillator rate, kHz |
| parent_khz_i | input | 32 | Parent input rate, kHz |
| pdiv_i | input | 4 | Reference divider (0 doubles) |
| ndiv_int_i | input | NINT_W | Integer feedback divider |
| ndiv_frac_i | input | NFRAC_W | Fractional feedback divider |
| has_frac_i | input | 1 | PLL has a fractional divider |
| rst_active_low_i | input | 1 | Reset polarity select |
| lock_i | input | 1 | PLL lock flag |
| pwr_on_o | output | 1 | Power-up field |
| pll_rst_o | output | 2 | The two PLL reset bits |
| mode_o | output | 3 | Macro mode field |
| vco_upper_o | output | 32 | Upper oscillator control word |
| vco_lower_o | output | 32 | Lower oscillator control word |
| ndiv_int_o | output | NINT_W | Integer divider field |
| ndiv_frac_o | output | NFRAC_W | Fractional divider field |
| pdiv_o | output | 4 | Reference divider field |
| kp_o | output | 4 | Proportional gain field |
| ki_o | output | 3 | Integral gain field |
| ka_o | output | 3 | Accumulator gain field |
| step_o | output | 4 | Code of the field written this cycle |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_code_o | output | 2 | 0 ok, 1 rate, 2 reference, 3 no lock |
| locked_o | output | 1 | Lock seen in the last transaction |

## Verification
The hardest situations to reach are the edges of the poll budget and the sticky lower-word bit, because both depend on what earlier transactions left behind. The bench models the PLL as a flag that rises a chosen number of cycles after the reset-release step. It runs one transaction whose lock comes late but still inside the budget, and one whose lock never comes. It also sweeps both edges of every reference band under all three oscillator rows and several divider settings, and tracks the lower word across the runs so that the retained bit 30 is predicted arithmetically.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int RATE_W = 32;
  localparam int PDIV_W = 4;
  localparam int WORD_W = 32;
  localparam int KP_W   = 4;
  localparam int KI_W   = 3;
  localparam int LOW_BAND_BIT = 30;
  localparam int HIGH_BAND_BIT = 19;
  localparam logic [2:0] USER_MODE = 3'd7;

  typedef enum logic [3:0] {
    STEP_NONE = 4'd0, STEP_PWR = 4'd1, STEP_RST_ON = 4'd2, STEP_MODE = 4'd3,
    STEP_VUP = 4'd4, STEP_VLO = 4'd5, STEP_NINT = 4'd6, STEP_NFRAC = 4'd7,
    STEP_PDIV = 4'd8, STEP_GAINS = 4'd9, STEP_RST_OFF = 4'd10
  } step_t;

  localparam logic [1:0] ERR_NONE = 2'd0, ERR_RATE = 2'd1, ERR_REF = 2'd2, ERR_LOCK = 2'd3;
  localparam logic [1:0] ROW_MID = 2'd0, ROW_HIGH = 2'd1, ROW_TOP = 2'd2, ROW_BAD = 2'd3;

  function automatic logic [1:0] vco_row(input logic [RATE_W-1:0] khz);
    if (khz >= 32'd700000 && khz < 32'd2200000) return ROW_MID;
    if (khz >= 32'd2200000 && khz < 32'd3100000) return ROW_HIGH;
    if (khz >= 32'd3100000 && khz < 32'd4000000) return ROW_TOP;
    return ROW_BAD;
  endfunction

  function automatic logic [RATE_W:0] ref_khz(input logic [RATE_W-1:0] parent,
                                                input logic [PDIV_W-1:0] div);
    if (div == '0) return {parent, 1'b0};
    return {1'b0, parent / {{(RATE_W-PDIV_W){1'b0}}, div}};
  endfunction

  // band index 0..7, 8 = out of range
  function automatic logic [3:0] ref_band(input logic [RATE_W:0] r);
    if (r < 33'd10000)  return 4'd8;
    if (r < 33'd12500)  return 4'd0;
    if (r < 33'd15000)  return 4'd1;
    if (r < 33'd20000)  return 4'd2;
    if (r < 33'd25000)  return 4'd3;
    if (r < 33'd50000)  return 4'd4;
    if (r < 33'd75000)  return 4'd5;
    if (r < 33'd100000) return 4'd6;
    if (r < 33'd125000) return 4'd7;
    return 4'd8;
  endfunction

  // one nibble per band, band 0 in the lowest nibble
  function automatic logic [KP_W-1:0] kp_lookup(input logic [1:0] row, input logic [2:0] band);
    logic [31:0] t;
    case (row)
      ROW_MID:  t = 32'hA987_7665;
      ROW_HIGH: t = 32'h9876_5544;
      default:  t = 32'hA987_6554;
    endcase
    return t[band*4 +: 4];
  endfunction
endpackage

// File: rtl/pll_gain_sel.sv
module pll_gain_sel
  import pll_seq_pkg::*;
(
  input  logic [RATE_W-1:0] vco_khz,
  input  logic [RATE_W-1:0] parent_khz,
  input  logic [PDIV_W-1:0] pdiv,
  output logic              rate_ok,
  output logic              ref_ok,
  output logic [KP_W-1:0]   kp,
  output logic [KI_W-1:0]   ki,
  output logic              low_band,
  output logic              high_band
);
  logic [1:0]      row;
  logic [RATE_W:0] refk;
  logic [3:0]      band;

  always_comb begin
    row       = vco_row(vco_khz);
    refk      = ref_khz(parent_khz, pdiv);
    band      = ref_band(refk);
    rate_ok   = (row != ROW_BAD);
    ref_ok    = (band < 4'd8);
    kp        = kp_lookup(row, band[2:0]);
    ki        = (row == ROW_MID) ? 3'd4 : 3'd3;
    low_band  = (vco_khz >= 32'd700000) && (vco_khz < 32'd1200000);
    high_band = (vco_khz >= 32'd2200000);
  end
endmodule

// File: rtl/pll_lock_poll.sv
module pll_lock_poll #(
  parameter int POLL_GAP  = 4,
  parameter int MAX_POLLS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic lock_in,
  output logic hit,
  output logic miss
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int TRY_W = $clog2(MAX_POLLS + 1);

  logic             active;
  logic [GAP_W-1:0] gap_cnt;
  logic [TRY_W-1:0] tries;
  logic             sample_now;

  assign sample_now = active && (gap_cnt == GAP_W'(POLL_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; gap_cnt <= '0; tries <= '0; hit <= 1'b0; miss <= 1'b0;
    end else begin
      hit  <= 1'b0;
      miss <= 1'b0;
      if (go) begin
        active <= 1'b1; gap_cnt <= '0; tries <= '0;
      end else if (sample_now) begin
        gap_cnt <= '0;
        if (lock_in) begin
          hit <= 1'b1; active <= 1'b0;
        end else if (tries == TRY_W'(MAX_POLLS - 1)) begin
          miss <= 1'b1; active <= 1'b0;
        end else begin
          tries <= tries + 1'b1;
        end
      end else if (active) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R9
  poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(MAX_POLLS));
  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int NINT_W    = 10,
  parameter int NFRAC_W   = 20,
  parameter int POLL_GAP  = 4,
  parameter int MAX_POLLS = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [31:0]        vco_khz_i,
  input  logic [31:0]        parent_khz_i,
  input  logic [3:0]         pdiv_i,
  input  logic [NINT_W-1:0]  ndiv_int_i,
  input  logic [NFRAC_W-1:0] ndiv_frac_i,
  input  logic               has_frac_i,
  input  logic               rst_active_low_i,
  input  logic               lock_i,
  output logic               pwr_on_o,
  output logic [1:0]         pll_rst_o,
  output logic [2:0]         mode_o,
  output logic [31:0]        vco_upper_o,
  output logic [31:0]        vco_lower_o,
  output logic [NINT_W-1:0]  ndiv_int_o,
  output logic [NFRAC_W-1:0] ndiv_frac_o,
  output logic [3:0]         pdiv_o,
  output logic [3:0]         kp_o,
  output logic [2:0]         ki_o,
  output logic [2:0]         ka_o,
  output logic [3:0]         step_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         err_code_o,
  output logic               locked_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PWR, S_RSTON, S_MODE, S_VUP, S_VLO,
    S_NINT, S_NFRAC, S_PDIV, S_GAINS, S_RSTOFF, S_POLL
  } state_t;

  state_t             state_q;
  logic [RATE_W-1:0]  cfg_vco_q, cfg_parent_q;
  logic [PDIV_W-1:0]  cfg_pdiv_q;
  logic [NINT_W-1:0]  cfg_nint_q;
  logic [NFRAC_W-1:0] cfg_nfrac_q;
  logic               cfg_frac_q, cfg_low_q;
  step_t              step_q;
  logic               go_poll_q;

  // named events for assertions
  logic rate_ok, ref_ok, low_band, high_band, poll_hit, poll_miss;
  logic [KP_W-1:0] kp_sel;
  logic [KI_W-1:0] ki_sel;
  logic start_accept;
  logic [1:0] rst_assert_val;

  assign start_accept   = start_i && (state_q == S_IDLE);
  assign rst_assert_val = cfg_low_q ? 2'b11 : 2'b00;

  pll_gain_sel u_gain (
    .vco_khz(cfg_vco_q), .parent_khz(cfg_parent_q), .pdiv(cfg_pdiv_q),
    .rate_ok(rate_ok), .ref_ok(ref_ok), .kp(kp_sel), .ki(ki_sel),
    .low_band(low_band), .high_band(high_band)
  );

  pll_lock_poll #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .go(go_poll_q), .lock_in(lock_i),
    .hit(poll_hit), .miss(poll_miss)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; step_q <= STEP_NONE; go_poll_q <= 1'b0;
      cfg_vco_q <= '0; cfg_parent_q <= '0; cfg_pdiv_q <= '0;
      cfg_nint_q <= '0; cfg_nfrac_q <= '0; cfg_frac_q <= 1'b0; cfg_low_q <= 1'b0;
      pwr_on_o <= 1'b0; pll_rst_o <= 2'b00; mode_o <= '0;
      vco_upper_o <= '1; vco_lower_o <= '0;
      ndiv_int_o <= '0; ndiv_frac_o <= '0; pdiv_o <= '0;
      kp_o <= '0; ki_o <= '0; ka_o <= '0;
      done_o <= 1'b0; err_code_o <= ERR_NONE; locked_o <= 1'b0;
    end else begin
      step_q    <= STEP_NONE;
      done_o    <= 1'b0;
      go_poll_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_accept) begin
          cfg_vco_q <= vco_khz_i; cfg_parent_q <= parent_khz_i; cfg_pdiv_q <= pdiv_i;
          cfg_nint_q <= ndiv_int_i; cfg_nfrac_q <= ndiv_frac_i;
          cfg_frac_q <= has_frac_i; cfg_low_q <= rst_active_low_i;
          err_code_o <= ERR_NONE; locked_o <= 1'b0;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!rate_ok || !ref_ok) begin
            err_code_o <= rate_ok ? ERR_REF : ERR_RATE;
            done_o <= 1'b1;
            state_q <= S_IDLE;
          end else state_q <= S_PWR;
        end
        S_PWR:   begin pwr_on_o <= 1'b1; step_q <= STEP_PWR; state_q <= S_RSTON; end
        S_RSTON: begin pll_rst_o <= rst_assert_val; step_q <= STEP_RST_ON; state_q <= S_MODE; end
        S_MODE:  begin mode_o <= USER_MODE; step_q <= STEP_MODE; state_q <= S_VUP; end
        S_VUP:   begin vco_upper_o <= '0; step_q <= STEP_VUP; state_q <= S_VLO; end
        S_VLO: begin
          if (low_band) vco_lower_o[LOW_BAND_BIT] <= 1'b1;
          vco_lower_o[HIGH_BAND_BIT] <= high_band;
          step_q <= STEP_VLO; state_q <= S_NINT;
        end
        S_NINT: begin
          ndiv_int_o <= cfg_nint_q; step_q <= STEP_NINT;
          state_q <= cfg_frac_q ? S_NFRAC : S_PDIV;
        end
        S_NFRAC: begin ndiv_frac_o <= cfg_nfrac_q; step_q <= STEP_NFRAC; state_q <= S_PDIV; end
        S_PDIV:  begin pdiv_o <= cfg_pdiv_q; step_q <= STEP_PDIV; state_q <= S_GAINS; end
        S_GAINS: begin
          kp_o <= kp_sel; ki_o <= ki_sel; ka_o <= '0;
          step_q <= STEP_GAINS; state_q <= S_RSTOFF;
        end
        S_RSTOFF: begin
          pll_rst_o <= ~rst_assert_val; step_q <= STEP_RST_OFF;
          go_poll_q <= 1'b1; state_q <= S_POLL;
        end
        S_POLL: begin
          if (poll_hit) begin
            locked_o <= 1'b1; done_o <= 1'b1; state_q <= S_IDLE;
          end else if (poll_miss) begin
            err_code_o <= ERR_LOCK; done_o <= 1'b1; state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign step_o = step_q;
  assign busy_o = (state_q != S_IDLE);

  // R7
  rst_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_rst_o) |-> (step_o == STEP_RST_ON || step_o == STEP_RST_OFF));
  // R2
  rate_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHECK && !rate_ok) |=> (done_o && err_code_o == ERR_RATE && step_o == STEP_NONE));
  // R4
  kp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == STEP_GAINS) |-> (kp_o >= 4'd4 && kp_o <= 4'd10 && ka_o == 3'd0));
  // R9
  lock_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> (done_o && err_code_o == ERR_NONE));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(cfg_vco_q) && $stable(cfg_nint_q)));
  // R5
  gains_after_pdiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == STEP_GAINS) |-> ($past(step_o) == STEP_PDIV));
endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 0, has_frac_i = 0, rst_active_low_i = 0;
  logic [31:0] vco_khz_i = 0, parent_khz_i = 0;
  logic [3:0]  pdiv_i = 0;
  logic [9:0]  ndiv_int_i = 0;
  logic [19:0] ndiv_frac_i = 0;
  logic        lock_i;
  logic        pwr_on_o, busy_o, done_o, locked_o;
  logic [1:0]  pll_rst_o, err_code_o;
  logic [2:0]  mode_o, ki_o, ka_o;
  logic [31:0] vco_upper_o, vco_lower_o;
  logic [9:0]  ndiv_int_o;
  logic [19:0] ndiv_frac_o;
  logic [3:0]  pdiv_o, kp_o, step_o;

  pll_reprog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vco_khz_i(vco_khz_i),
    .parent_khz_i(parent_khz_i), .pdiv_i(pdiv_i), .ndiv_int_i(ndiv_int_i),
    .ndiv_frac_i(ndiv_frac_i), .has_frac_i(has_frac_i),
    .rst_active_low_i(rst_active_low_i), .lock_i(lock_i),
    .pwr_on_o(pwr_on_o), .pll_rst_o(pll_rst_o), .mode_o(mode_o),
    .vco_upper_o(vco_upper_o), .vco_lower_o(vco_lower_o),
    .ndiv_int_o(ndiv_int_o), .ndiv_frac_o(ndiv_frac_o), .pdiv_o(pdiv_o),
    .kp_o(kp_o), .ki_o(ki_o), .ka_o(ka_o), .step_o(step_o), .busy_o(busy_o),
    .done_o(done_o), .err_code_o(err_code_o), .locked_o(locked_o)
  );

  // PLL model: lock rises lk_lat cycles after the reset-release step
  int lk_cnt = 0, lk_lat = 5;
  logic lk_en = 1'b1;
  always @(posedge clk) begin
    if (step_o == 4'd2) lk_cnt <= 0;
    else if (step_o == 4'd10) lk_cnt <= 1;
    else if (lk_cnt > 0 && lk_cnt < 100000) lk_cnt <= lk_cnt + 1;
  end
  assign lock_i = lk_en && (lk_cnt > lk_lat);

  int n_chk = 0, n_fail = 0;
  logic [31:0] lo_model = 0;
  logic [19:0] frac_model = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_band(input longint r);
    longint edges[9] = '{10000, 12500, 15000, 20000, 25000, 50000, 75000, 100000, 125000};
    for (int i = 0; i < 8; i++) if (r >= edges[i] && r < edges[i+1]) return i;
    return -1;
  endfunction

  function automatic int exp_row(input longint v);
    if (v >= 700000 && v < 2200000) return 0;
    if (v >= 2200000 && v < 3100000) return 1;
    if (v >= 3100000 && v < 4000000) return 2;
    return -1;
  endfunction

  function automatic int exp_kp(input int row, input int band);
    int m[8] = '{5, 6, 6, 7, 7, 8, 9, 10};
    int h[8] = '{4, 4, 5, 5, 6, 7, 8, 9};
    int t[8] = '{4, 5, 5, 6, 7, 8, 9, 10};
    return row == 0 ? m[band] : (row == 1 ? h[band] : t[band]);
  endfunction

  task automatic run(input longint vco, input longint parent, input int pd,
                     input int nint, input int nfrac, input logic hasf,
                     input logic alow, input logic lken, input int lat, input logic poke);
    int steps[16];
    int nst = 0, cyc = 0;
    logic [1:0] rst_seen = 2'bxx;
    longint refk;
    int row, band, exp_err;
    logic got_done = 0;
    int exp_seq[10];
    int nexp = 0;

    lk_en = lken; lk_lat = lat;
    @(negedge clk);
    vco_khz_i = vco[31:0]; parent_khz_i = parent[31:0]; pdiv_i = pd[3:0];
    ndiv_int_i = nint[9:0]; ndiv_frac_i = nfrac[19:0];
    has_frac_i = hasf; rst_active_low_i = alow; start_i = 1;
    @(negedge clk); start_i = 0;
    while (cyc < 3000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 4) begin
        start_i = 1; vco_khz_i = 32'd3500000; ndiv_int_i = 10'd1;
      end else start_i = 0;
      if (step_o != 0 && nst < 16) begin steps[nst] = step_o; nst++; end
      if (step_o == 4'd2) rst_seen = pll_rst_o;
      if (done_o) begin got_done = 1; break; end
    end
    chk(got_done, "R9 done pulse", got_done, 1);

    refk = (pd == 0) ? parent * 2 : parent / pd;
    row = exp_row(vco); band = exp_band(refk);
    exp_err = (row < 0) ? 1 : (band < 0) ? 2 : (lken && lat < 350) ? 0 : 3;
    chk(err_code_o == exp_err[1:0], "R2 R3 R9 error code", err_code_o, exp_err);
    if (exp_err == 1 || exp_err == 2) begin
      chk(nst == 0, "R2 R3 no field write on reject", nst, 0);
      chk(vco_lower_o == lo_model && ndiv_frac_o == frac_model, "R2 R3 fields untouched", vco_lower_o, lo_model);
      return;
    end
    // expected order
    for (int s = 1; s <= 10; s++) if (s != 7 || hasf) begin exp_seq[nexp] = s; nexp++; end
    chk(nst == nexp, "R5 R8 step count", nst, nexp);
    for (int i = 0; i < nexp && i < nst; i++)
      chk(steps[i] == exp_seq[i], "R5 step order", steps[i], exp_seq[i]);
    chk(rst_seen == (alow ? 2'b11 : 2'b00), "R7 reset asserted", rst_seen, alow ? 3 : 0);
    chk(pll_rst_o == (alow ? 2'b00 : 2'b11), "R7 reset released", pll_rst_o, alow ? 0 : 3);
    chk(kp_o == exp_kp(row, band), "R4 kp", kp_o, exp_kp(row, band));
    chk(ki_o == (row == 0 ? 4 : 3), "R2 ki", ki_o, row == 0 ? 4 : 3);
    chk(ka_o == 0 && mode_o == 7 && pwr_on_o, "R10 ka mode power", {ka_o, mode_o}, 7);
    chk(ndiv_int_o == nint[9:0] && pdiv_o == pd[3:0], "R10 dividers", ndiv_int_o, nint);
    if (hasf) frac_model = nfrac[19:0];
    chk(ndiv_frac_o == frac_model, "R8 fractional field", ndiv_frac_o, frac_model);
    if (vco >= 700000 && vco < 1200000) lo_model[30] = 1'b1;
    lo_model[19] = (vco >= 2200000);
    chk(vco_upper_o == 0 && vco_lower_o == lo_model, "R6 oscillator words", vco_lower_o, lo_model);
    chk(locked_o == (exp_err == 0), "R9 locked", locked_o, exp_err == 0);
  endtask

  initial begin
    longint vcos[4] = '{900000, 1500000, 2500000, 3500000};
    longint refs[16] = '{10000, 12499, 12500, 14999, 15000, 19999, 20000, 24999,
                         25000, 49999, 50000, 74999, 75000, 99999, 100000, 124999};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vco_upper_o == 32'hFFFF_FFFF && vco_lower_o == 0 && pll_rst_o == 0 && mode_o == 0
        && kp_o == 0 && step_o == 0 && !busy_o && !done_o && err_code_o == 0 && !locked_o
        && !pwr_on_o && ndiv_frac_o == 0, "R1 reset values", vco_upper_o, 32'hFFFF_FFFF);
    rst_n = 1;
    // R3 R4 sweep across all bands and rows
    for (int v = 0; v < 4; v++)
      for (int r = 0; r < 16; r++) begin
        int pd = (r % 2 == 0) ? ((r / 2) % 4) : 1;
        longint par = (pd == 0) ? refs[r] / 2 : refs[r] * pd;
        run(vcos[v], par, pd, 100 + r, 1000 * v + r, (r % 3) != 0, r[0], 1, 5, 0);
      end
    // R2 rate edges
    run(700000, 20000, 1, 50, 7, 1, 1, 1, 3, 0);
    run(1199999, 20000, 1, 51, 8, 1, 0, 1, 3, 0);
    run(1200000, 20000, 1, 52, 9, 0, 1, 1, 3, 0);
    run(2199999, 20000, 1, 53, 9, 1, 1, 1, 3, 0);
    run(2200000, 20000, 1, 54, 10, 1, 0, 1, 3, 0);
    run(3099999, 20000, 1, 55, 11, 1, 1, 1, 3, 0);
    run(3100000, 20000, 1, 56, 12, 1, 0, 1, 3, 0);
    run(3999999, 20000, 1, 57, 13, 1, 1, 1, 3, 0);
    run(699999, 20000, 1, 58, 14, 1, 1, 1, 3, 0);
    run(4000000, 20000, 1, 59, 15, 1, 1, 1, 3, 0);
    run(0, 5000, 1, 60, 16, 1, 1, 1, 3, 0);  // both bad: rate code wins
    // R3 reference out of range
    run(1500000, 9999, 1, 61, 17, 1, 1, 1, 3, 0);
    run(1500000, 125000, 1, 62, 18, 1, 1, 1, 3, 0);
    run(1500000, 62500, 0, 63, 19, 1, 1, 1, 3, 0);
    run(1500000, 62499, 0, 64, 20, 1, 0, 1, 3, 0);
    // R8 no fractional divider keeps field
    run(2500000, 30000, 2, 65, 999, 0, 1, 1, 3, 0);
    // R9 late lock inside budget, then no lock
    run(3500000, 60000, 3, 66, 21, 1, 1, 1, 300, 0);
    run(900000, 60000, 3, 67, 22, 1, 0, 0, 3, 0);
    // R11 start while busy ignored
    run(1000000, 40000, 1, 68, 23, 1, 1, 1, 5, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule